// File: doc/BRIEF.md
# Card Clock Divider and Selector

This block produces the clock driven onto a smart-card contact. It runs from a fast reference clock, which is also handed out unchanged on a separate pin so that other devices can share it. Two modes are selected by a single pin.

In asynchronous mode, a two-bit ratio code divides the reference. A run request from the activation sequencer starts and stops the card clock. Starting, stopping and changes of ratio all happen only at the end of a low phase of the divided clock. As a result the card never sees a runt pulse, and a stopped clock always rests low. One code passes the reference through undivided, in which case the duty cycle is the reference's own.

In synchronous mode, the card clock is a plain copy of an external strobe pin, which the host toggles to clock memory cards. In this mode the ratio code and the run request have no effect on the output.

Top module: `cardclk_gen`

## Requirements
- R1: In asynchronous mode with the run request high, the ratio code `div_sel_i` selects the card clock period in reference cycles. Code 2'b00 gives 8, code 2'b10 gives 4 and code 2'b11 gives 2. Each period is high for exactly half of it and low for the other half.
- R2: Code 2'b01 passes the reference through. The card clock equals the reference, gated. The first full pulse begins at the second reference rising edge after the request is seen, and the last pulse is always a complete one.
- R3: When `sync_mode_i` is 1, `card_clk_o` equals `strobe_i`, whatever the ratio code and run request are.
- R4: When `sync_mode_i` is 0, `strobe_i` has no effect on `card_clk_o`.
- R5: `ref_copy_o` always equals the reference clock `clk_i`.
- R6: When the run request falls, the period in progress completes, both its high and its low phase. After that the card clock stays low.
- R7: A divided clock starts only from the idle low state. From idle, a run request seen at a reference rising edge drives the card clock high at that edge. No high phase is ever shorter than half the selected period.
- R8: A ratio change while running takes effect only at the next low-to-high boundary. The period in progress keeps its old length.
- R9: While `rst_ni` is low, and afterwards until a run request arrives, the asynchronous card clock is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock; the block's only clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| div_sel_i | input | SEL_W (2) | Ratio code: 00 /8, 01 pass-through, 10 /4, 11 /2 |
| sync_mode_i | input | 1 | 1 selects synchronous (strobe) mode, 0 selects divided mode |
| strobe_i | input | 1 | External clock for synchronous cards |
| run_req_i | input | 1 | Sequencer request: 1 runs the divided clock, 0 stops it low |
| card_clk_o | output | 1 | Clock to the card contact |
| ref_copy_o | output | 1 | Buffered copy of the reference |

## Verification
The divided output is registered. A request or code change applied before rising edge N is therefore first visible just after edge N, and the bench samples 1 ns after each rising edge, counting pattern positions from that edge. The pass-through path adds a falling-edge enable stage, so its first pulse is due at edge N+1, and a stop leaves exactly one further high reference phase. The strobe bypass and the reference copy are combinational, and the bench checks them in the same cycle on both clock phases.

// File: rtl/cardclk_pkg.sv
package cardclk_pkg;

   // Ratio codes; the two-bit encoding is not monotonic in the ratio.
   typedef enum logic [1:0] {
      RC_SLOWEST = 2'b00,
      RC_THROUGH = 2'b01,
      RC_QUARTER = 2'b10,
      RC_EIGHTH  = 2'b11
   } ratio_code_e;

   // Half period, in reference cycles, of a divided ratio code.
   // Returns 0 for the pass-through code.
   function automatic int unsigned half_of(input logic [1:0] code,
                                           input int unsigned div_max);
      int unsigned h;
      case (code)
         RC_SLOWEST: h = div_max / 2;
         RC_QUARTER: h = div_max / 4;
         RC_EIGHTH:  h = div_max / 8;
         default:    h = 0;
      endcase
      return h;
   endfunction

endpackage

// File: rtl/cardclk_ratio_dec.sv
module cardclk_ratio_dec #(
   parameter int unsigned DIV_MAX      = 8,
   parameter bit          PASS_THRU_EN = 1'b1,
   parameter int unsigned HALF_W       = 3
) (
   input  logic [1:0]        sel_i,
   output logic [HALF_W-1:0] half_o,
   output logic              pass_o
);
   import cardclk_pkg::*;

   localparam int unsigned FASTEST_HALF = DIV_MAX / 8;

   generate
      if (PASS_THRU_EN) begin : g_pass
         always_comb begin
            pass_o = (sel_i == RC_THROUGH);
            half_o = HALF_W'(half_of(sel_i, DIV_MAX));
         end
      end else begin : g_nopass
         // Without a bypass gate the through code falls back to the fastest ratio.
         always_comb begin
            pass_o = 1'b0;
            if (sel_i == RC_THROUGH) half_o = HALF_W'(FASTEST_HALF);
            else                     half_o = HALF_W'(half_of(sel_i, DIV_MAX));
         end
      end
   endgenerate

endmodule

// File: rtl/cardclk_div.sv
module cardclk_div #(
   parameter int unsigned HALF_W = 3
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              run_i,
   input  logic [HALF_W-1:0] half_i,
   input  logic              pass_sel_i,
   output logic              phase_o,
   output logic              pass_o
);
   localparam logic [HALF_W-1:0] ONE = HALF_W'(1);

   logic              phase_q;
   logic              pass_q;
   logic [HALF_W-1:0] cnt_q;
   logic [HALF_W-1:0] hold_q;
   logic              at_edge;

   // End of a low phase (or idle): the only point where decisions are taken.
   assign at_edge = !phase_q && (cnt_q == '0);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         phase_q <= 1'b0;
         pass_q  <= 1'b0;
         cnt_q   <= '0;
         hold_q  <= ONE;
      end else if (at_edge) begin
         if (pass_q) begin
            // Leaving pass-through always passes one idle cycle first.
            pass_q <= run_i && pass_sel_i;
         end else if (run_i && pass_sel_i) begin
            pass_q <= 1'b1;
         end else if (run_i) begin
            phase_q <= 1'b1;
            cnt_q   <= half_i - ONE;
            hold_q  <= half_i;
         end
      end else if (cnt_q == '0) begin
         phase_q <= 1'b0;
         cnt_q   <= hold_q - ONE;
      end else begin
         cnt_q <= cnt_q - ONE;
      end
   end

   assign phase_o = phase_q;
   assign pass_o  = pass_q;

   AST_STOP_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (at_edge && !run_i && !pass_q) |=> (!phase_q && !pass_q)); // R6

   AST_NO_RUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (phase_q && cnt_q != '0) |=> phase_q); // R7

   AST_START_ON_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(phase_q) |-> $past(run_i)); // R7

   AST_RATIO_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !at_edge |=> $stable(hold_q)); // R8

   AST_MODES_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(phase_q && pass_q)); // R2

endmodule

// File: rtl/cardclk_gate.sv
module cardclk_gate #(
   parameter bit PASS_THRU_EN = 1'b1
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic pass_i,
   output logic gclk_o
);
   generate
      if (PASS_THRU_EN) begin : g_gate
         logic en_q;

         // Enable changes only while the reference is low.
         always_ff @(negedge clk_i or negedge rst_ni) begin
            if (!rst_ni) en_q <= 1'b0;
            else         en_q <= pass_i;
         end

         assign gclk_o = clk_i & en_q;

         AST_GATE_TRACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
            en_q == pass_i); // R2
      end else begin : g_tie
         assign gclk_o = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/cardclk_gen.sv
module cardclk_gen #(
   parameter int unsigned DIV_MAX      = 8,
   parameter int unsigned SEL_W        = 2,
   parameter bit          PASS_THRU_EN = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [SEL_W-1:0] div_sel_i,
   input  logic             sync_mode_i,
   input  logic             strobe_i,
   input  logic             run_req_i,
   output logic             card_clk_o,
   output logic             ref_copy_o
);
   localparam int unsigned HALF_W = $clog2(DIV_MAX / 2 + 1);

   generate
      if (SEL_W != 2) begin : g_bad_sel
         $error("cardclk_gen: ratio code must be two bits");
      end
      if (DIV_MAX < 8 || (DIV_MAX & (DIV_MAX - 1)) != 0) begin : g_bad_div
         $error("cardclk_gen: DIV_MAX must be a power of two of at least 8");
      end
   endgenerate

   logic [HALF_W-1:0] half;
   logic              pass_sel;
   logic              div_phase;
   logic              pass_on;
   logic              pass_clk;

   cardclk_ratio_dec #(
      .DIV_MAX     (DIV_MAX),
      .PASS_THRU_EN(PASS_THRU_EN),
      .HALF_W      (HALF_W)
   ) u_dec (
      .sel_i (div_sel_i[1:0]),
      .half_o(half),
      .pass_o(pass_sel)
   );

   cardclk_div #(
      .HALF_W(HALF_W)
   ) u_div (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .run_i     (run_req_i),
      .half_i    (half),
      .pass_sel_i(pass_sel),
      .phase_o   (div_phase),
      .pass_o    (pass_on)
   );

   cardclk_gate #(
      .PASS_THRU_EN(PASS_THRU_EN)
   ) u_gate (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .pass_i(pass_on),
      .gclk_o(pass_clk)
   );

   assign ref_copy_o = clk_i;
   assign card_clk_o = sync_mode_i ? strobe_i : (div_phase | pass_clk);

endmodule

// File: tb/cardclk_gen_tb.sv
`timescale 1ns/1ps
module cardclk_gen_tb;
   logic       clk = 1'b0;
   logic       rst_n;
   logic [1:0] sel;
   logic       sync_m;
   logic       strobe;
   logic       run;
   logic       card_clk;
   logic       ref_copy;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   cardclk_gen u_dut (
      .clk_i      (clk),
      .rst_ni     (rst_n),
      .div_sel_i  (sel),
      .sync_mode_i(sync_m),
      .strobe_i   (strobe),
      .run_req_i  (run),
      .card_clk_o (card_clk),
      .ref_copy_o (ref_copy)
   );

   // {ratio code, half period in reference cycles}
   localparam logic [4:0] VEC [3] = '{ {2'b00, 3'd4}, {2'b10, 3'd2}, {2'b11, 3'd1} };

   task automatic chk(input string req, input logic got, input logic exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %0b expected %0b at %0t", req, got, exp, $time);
      end
   endtask

   task automatic at_pos();
      @(posedge clk); #1;
   endtask

   task automatic at_neg();
      @(negedge clk); #1;
   endtask

   task automatic go_idle();
      @(negedge clk);
      run = 1'b0; sync_m = 1'b0; strobe = 1'b0;
      repeat (20) @(posedge clk);
   endtask

   initial begin
      #(200000 * 4);
      errors++;
      $display("FAIL watchdog: got timeout expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      rst_n = 1'b0; sel = 2'b00; sync_m = 1'b0; strobe = 1'b0; run = 1'b1;
      // R9: low throughout reset even with run requested
      repeat (3) begin
         at_pos(); chk("R9 reset", card_clk, 1'b0);
      end
      @(negedge clk); run = 1'b0; rst_n = 1'b1;
      repeat (4) begin
         at_pos(); chk("R9 idle", card_clk, 1'b0);
      end

      // R5: reference copy on both phases
      repeat (3) begin
         at_pos(); chk("R5 high", ref_copy, 1'b1);
         at_neg(); chk("R5 low", ref_copy, 1'b0);
      end

      // R1/R7: table of divided ratios, then R6 stop at a boundary
      for (int v = 0; v < 3; v++) begin
         int h;
         h = int'(VEC[v][2:0]);
         @(negedge clk); sel = VEC[v][4:3]; run = 1'b1;
         for (int k = 0; k < 16; k++) begin
            at_pos();
            chk("R1 R7 ratio pattern", card_clk, ((k / h) % 2) == 0);
         end
         @(negedge clk); run = 1'b0;
         for (int k = 0; k < 6; k++) begin
            at_pos(); chk("R6 stopped high", card_clk, 1'b0);
            at_neg(); chk("R6 stopped low", card_clk, 1'b0);
         end
         go_idle();
      end

      // R6: stop in mid high phase at /8; the period completes
      @(negedge clk); sel = 2'b00; run = 1'b1;
      at_pos(); chk("R6 start", card_clk, 1'b1);
      at_pos(); chk("R6 start", card_clk, 1'b1);
      @(negedge clk); run = 1'b0;
      for (int k = 2; k < 14; k++) begin
         at_pos(); chk("R6 finish then low", card_clk, k < 4);
      end
      go_idle();

      // R8: switch /8 -> /2 during the high phase
      @(negedge clk); sel = 2'b00; run = 1'b1;
      at_pos(); at_pos();
      @(negedge clk); sel = 2'b11;
      for (int k = 2; k < 16; k++) begin
         at_pos();
         if (k < 8) chk("R8 old ratio kept", card_clk, k < 4);
         else       chk("R8 new ratio", card_clk, ((k - 8) % 2) == 0);
      end
      go_idle();

      // R2: pass-through
      @(negedge clk); sel = 2'b01; run = 1'b1;
      at_pos(); chk("R2 first edge held", card_clk, 1'b0);
      at_neg(); chk("R2 first low", card_clk, 1'b0);
      for (int k = 0; k < 5; k++) begin
         at_pos(); chk("R2 follows high", card_clk, 1'b1);
         at_neg(); chk("R2 follows low", card_clk, 1'b0);
      end
      @(negedge clk); run = 1'b0;
      at_pos(); chk("R2 last full pulse", card_clk, 1'b1);
      at_neg(); chk("R2 last pulse low", card_clk, 1'b0);
      for (int k = 0; k < 4; k++) begin
         at_pos(); chk("R2 stopped", card_clk, 1'b0);
      end
      go_idle();

      // R3: strobe bypass, divider running behind it
      @(negedge clk); sync_m = 1'b1; sel = 2'b11; run = 1'b1; strobe = 1'b0;
      for (int k = 0; k < 4; k++) begin
         at_pos(); chk("R3 strobe low", card_clk, 1'b0);
      end
      @(negedge clk); strobe = 1'b1;
      for (int k = 0; k < 4; k++) begin
         at_pos(); chk("R3 strobe high", card_clk, 1'b1);
         at_neg(); chk("R3 strobe high", card_clk, 1'b1);
      end
      go_idle();

      // R4: strobe toggling in divided mode with the clock stopped
      for (int k = 0; k < 8; k++) begin
         @(negedge clk); strobe = ~strobe;
         at_pos(); chk("R4 strobe ignored", card_clk, 1'b0);
      end
      @(negedge clk); strobe = 1'b0;

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule